// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Codec

This block pulls the per-channel A/B signaling out of a received 24-channel T1 serial stream and places programmed A/B signaling into an outgoing T1 stream. Every channel slot has eight bits, B1 first and B8 last, and B8 is the least significant bit. In the two signaling frames of a twelve-frame superframe, B8 of every channel carries signaling instead of voice. A frame is one framing bit followed by 24 eight-bit channel slots, 193 bits in all. Each direction has its own position counter. The counter is aligned by a sync pulse that marks the framing bit of the first frame of a superframe. Between pulses it free-runs.

On the receive side the captured A and B bits are held in twelve read-only registers. The captured bits are committed as one set at the close of each superframe. The received stream is also passed on, one cycle late, on a serial output. A single control bit chooses what that output carries in the robbed positions: the bit as received, or a forced one. On the transmit side twelve writable registers are staged. At each superframe start they are copied into an active set, and the active set replaces B8 of every channel in the signaling frames. A register port with a combinational read gives access to all of this. The design takes one serial bit per clock.

Top module: `rbs_codec`

## Requirements
- R1: After reset every register address reads 0 and both serial outputs are 0.
- R2: A sync pulse marks the framing bit (bit position 0) of frame 1. Each frame is 193 bit positions and a superframe is 12 frames. Until the first sync pulse on a side, that side does no robbing, insertion or capture, and its serial output repeats its input delayed by one cycle.
- R3: rx_ser_out equals rx_data from the previous cycle whenever the previous bit was not in a robbed position or the force bit is 0.
- R4: With the force bit at 1, rx_ser_out is 1 in the cycle after each robbed position. A robbed position is bit position 8·(c+1) of frame 6 or frame 12 for channel c = 0..23.
- R5: Receive register k (address k, 0..11) holds channel 2k in bits [7:4] and channel 2k+1 in bits [3:0]. Each nibble reads {A,B,A,B}, where A is the robbed bit of frame 6 and B is the robbed bit of frame 12.
- R6: The receive registers change only at the last bit of frame 12. New values are readable from the cycle after that bit, and a read during a superframe returns the previous superframe's values.
- R7: Transmit register k sits at address 12+k and reads back as written. Channel 2k uses bits [7:4] and channel 2k+1 uses bits [3:0]. In a nibble, bit 3 is A and bit 2 is B.
- R8: tx_ser_out is tx_data_in from the previous cycle. The exception is a robbed position of frame 6 or frame 12, where it carries that channel's active A or B bit.
- R9: The active transmit signaling is loaded from the registers only at the framing bit of frame 1. A write made during a superframe first shows in the next superframe.
- R10: Address 24 bit 0 is the force bit and reads back as {7'b0, force}. Writes to addresses 0..11 are ignored, and addresses 25..31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sync | input | 1 | Receive superframe sync, high on the framing bit of frame 1 |
| rx_data | input | 1 | Receive serial data |
| rx_ser_out | output | 1 | Receive serial data delayed one cycle, robbed positions optionally forced to 1 |
| tx_sync | input | 1 | Transmit superframe sync, high on the framing bit of frame 1 |
| tx_data_in | input | 1 | Transmit serial data before insertion |
| tx_ser_out | output | 1 | Transmit serial data delayed one cycle with signaling inserted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
A position counter that is off by even one bit shifts the robbed slot. That error shows on the serial outputs within the first signaling frame, at most 1158 cycles after sync, because a forced or inserted bit lands on a voice bit. A wrong capture index or a wrong commit moment shows only at the register port. It is therefore checked both during the next superframe and right after each one, so a bad commit is seen within one superframe. Staging errors on the transmit side show up as old or new bits in the wrong superframe.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int unsigned NIB_W = 4;

   typedef enum logic [1:0] {
      RGN_RX   = 2'd0,
      RGN_TX   = 2'd1,
      RGN_CTL  = 2'd2,
      RGN_NONE = 2'd3
   } rbs_region_e;

   function automatic logic [NIB_W-1:0] rx_nibble(input logic a, input logic b);
      return {a, b, a, b};
   endfunction
endpackage

// File: rtl/rbs_pos_ctr.sv
module rbs_pos_ctr #(
   parameter int unsigned CHANNELS    = 24,
   parameter int unsigned BITS_PER_CH = 8,
   parameter int unsigned FRAMES      = 12,
   parameter int unsigned A_FRAME     = 6,
   parameter int unsigned B_FRAME     = 12,
   localparam int unsigned FRAME_LEN  = 1 + CHANNELS * BITS_PER_CH,
   localparam int unsigned BIT_W      = $clog2(FRAME_LEN),
   localparam int unsigned FRM_W      = $clog2(FRAMES),
   localparam int unsigned CH_W       = $clog2(CHANNELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   output logic [BIT_W-1:0] bit_pos,
   output logic [FRM_W-1:0] frame_idx,
   output logic             locked,
   output logic             sf_start,
   output logic             sf_end,
   output logic             rob_a,
   output logic             rob_b,
   output logic [CH_W-1:0]  rob_ch
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
   localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRAMES - 1);
   localparam logic [BIT_W-1:0] BPC      = BIT_W'(BITS_PER_CH);
   localparam logic [FRM_W-1:0] A_IDX    = FRM_W'(A_FRAME - 1);
   localparam logic [FRM_W-1:0] B_IDX    = FRM_W'(B_FRAME - 1);

   logic [BIT_W-1:0] bit_q;
   logic [FRM_W-1:0] frm_q;
   logic             lock_q;
   logic             slot_lsb;

   always_comb begin
      bit_pos   = sync ? '0 : bit_q;
      frame_idx = sync ? '0 : frm_q;
      locked    = sync | lock_q;
      slot_lsb  = locked && (bit_pos != '0) && ((bit_pos % BPC) == '0);
      rob_ch    = CH_W'((bit_pos / BPC) - BIT_W'(1));
      rob_a     = slot_lsb && (frame_idx == A_IDX);
      rob_b     = slot_lsb && (frame_idx == B_IDX);
      sf_start  = locked && (bit_pos == '0) && (frame_idx == '0);
      sf_end    = locked && (bit_pos == LAST_BIT) && (frame_idx == LAST_FRM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q  <= '0;
         frm_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         lock_q <= locked;
         if (bit_pos == LAST_BIT) begin
            bit_q <= '0;
            frm_q <= (frame_idx == LAST_FRM) ? '0 : frame_idx + FRM_W'(1);
         end else begin
            bit_q <= bit_pos + BIT_W'(1);
            frm_q <= frame_idx;
         end
      end
   end
endmodule

// File: rtl/rbs_rx_cap.sv
module rbs_rx_cap #(
   parameter int unsigned CHANNELS = 24,
   localparam int unsigned CH_W    = $clog2(CHANNELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_data,
   input  logic                rob_a,
   input  logic                rob_b,
   input  logic [CH_W-1:0]     rob_ch,
   input  logic                sf_end,
   input  logic                force_ones,
   output logic                rx_ser_out,
   output logic [CHANNELS-1:0] sig_a,
   output logic [CHANNELS-1:0] sig_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) rx_ser_out <= 1'b0;
      else        rx_ser_out <= (force_ones && (rob_a || rob_b)) ? 1'b1 : rx_data;
   end

   for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
      logic sh_a, sh_b, com_a, com_b, nxt_a, nxt_b;

      always_comb begin
         nxt_a = (rob_a && rob_ch == CH_W'(i)) ? rx_data : sh_a;
         nxt_b = (rob_b && rob_ch == CH_W'(i)) ? rx_data : sh_b;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_a  <= 1'b0;
            sh_b  <= 1'b0;
            com_a <= 1'b0;
            com_b <= 1'b0;
         end else begin
            sh_a <= nxt_a;
            sh_b <= nxt_b;
            if (sf_end) begin
               com_a <= nxt_a;
               com_b <= nxt_b;
            end
         end
      end

      assign sig_a[i] = com_a;
      assign sig_b[i] = com_b;
   end
endmodule

// File: rtl/rbs_tx_ins.sv
module rbs_tx_ins #(
   parameter int unsigned CHANNELS = 24,
   localparam int unsigned CH_W    = $clog2(CHANNELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_data_in,
   input  logic                rob_a,
   input  logic                rob_b,
   input  logic [CH_W-1:0]     rob_ch,
   input  logic                sf_start,
   input  logic [CHANNELS-1:0] stage_a,
   input  logic [CHANNELS-1:0] stage_b,
   output logic [CHANNELS-1:0] act_a,
   output logic [CHANNELS-1:0] act_b,
   output logic                tx_ser_out
);
   logic ins_a, ins_b;

   always_comb begin
      ins_a = 1'b0;
      ins_b = 1'b0;
      for (int c = 0; c < CHANNELS; c++) begin
         if (rob_ch == CH_W'(c)) begin
            ins_a = act_a[c];
            ins_b = act_b[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_a      <= '0;
         act_b      <= '0;
         tx_ser_out <= 1'b0;
      end else begin
         if (sf_start) begin
            act_a <= stage_a;
            act_b <= stage_b;
         end
         tx_ser_out <= rob_a ? ins_a : (rob_b ? ins_b : tx_data_in);
      end
   end
endmodule

// File: rtl/rbs_regs.sv
module rbs_regs
   import rbs_pkg::*;
#(
   parameter int unsigned CHANNELS   = 24,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned CH_PER_REG = DATA_W / NIB_W,
   localparam int unsigned NUM_REGS   = CHANNELS / CH_PER_REG,
   localparam int unsigned CTL_ADDR   = 2 * NUM_REGS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [CHANNELS-1:0] sig_a,
   input  logic [CHANNELS-1:0] sig_b,
   output logic [CHANNELS-1:0] stage_a,
   output logic [CHANNELS-1:0] stage_b,
   output logic                force_ones
);
   logic [DATA_W-1:0] tx_mem  [NUM_REGS];
   logic [DATA_W-1:0] rx_view [NUM_REGS];
   rbs_region_e       region;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic hit;
      assign hit = reg_wr && (reg_addr == ADDR_W'(NUM_REGS + k));

      always_ff @(posedge clk) begin
         if (!rst_n)   tx_mem[k] <= '0;
         else if (hit) tx_mem[k] <= reg_wdata;
      end

      for (genvar j = 0; j < CH_PER_REG; j++) begin : g_slot
         localparam int unsigned CH  = k * CH_PER_REG + j;
         localparam int unsigned TOP = DATA_W - 1 - NIB_W * j;
         assign rx_view[k][TOP -: NIB_W] = rx_nibble(sig_a[CH], sig_b[CH]);
         assign stage_a[CH] = tx_mem[k][TOP];
         assign stage_b[CH] = tx_mem[k][TOP-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         force_ones <= 1'b0;
      else if (reg_wr && reg_addr == ADDR_W'(CTL_ADDR))
         force_ones <= reg_wdata[0];
   end

   always_comb begin
      if (reg_addr < ADDR_W'(NUM_REGS))       region = RGN_RX;
      else if (reg_addr < ADDR_W'(CTL_ADDR))  region = RGN_TX;
      else if (reg_addr == ADDR_W'(CTL_ADDR)) region = RGN_CTL;
      else                                    region = RGN_NONE;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (region)
         RGN_RX: begin
            for (int k = 0; k < NUM_REGS; k++)
               if (reg_addr == ADDR_W'(k)) reg_rdata = rx_view[k];
         end
         RGN_TX: begin
            for (int k = 0; k < NUM_REGS; k++)
               if (reg_addr == ADDR_W'(NUM_REGS + k)) reg_rdata = tx_mem[k];
         end
         RGN_CTL:  reg_rdata = {{(DATA_W-1){1'b0}}, force_ones};
         RGN_NONE: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rbs_codec.sv
module rbs_codec #(
   parameter int unsigned CHANNELS    = 24,
   parameter int unsigned BITS_PER_CH = 8,
   parameter int unsigned FRAMES      = 12,
   parameter int unsigned A_FRAME     = 6,
   parameter int unsigned B_FRAME     = 12,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_sync,
   input  logic              rx_data,
   output logic              rx_ser_out,
   input  logic              tx_sync,
   input  logic              tx_data_in,
   output logic              tx_ser_out,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int unsigned FRAME_LEN  = 1 + CHANNELS * BITS_PER_CH;
   localparam int unsigned BIT_W      = $clog2(FRAME_LEN);
   localparam int unsigned FRM_W      = $clog2(FRAMES);
   localparam int unsigned CH_W       = $clog2(CHANNELS);
   localparam int unsigned CH_PER_REG = DATA_W / rbs_pkg::NIB_W;
   localparam int unsigned NUM_REGS   = CHANNELS / CH_PER_REG;

   if (DATA_W % rbs_pkg::NIB_W != 0 || CH_PER_REG == 0) begin : g_bad_dw
      $error("DATA_W must be a nonzero multiple of the nibble width");
   end
   if (CHANNELS % CH_PER_REG != 0 || CHANNELS < 2) begin : g_bad_ch
      $error("CHANNELS must fill the registers exactly");
   end
   if (FRAMES < 2 || A_FRAME < 1 || A_FRAME >= B_FRAME || B_FRAME > FRAMES) begin : g_bad_fr
      $error("signaling frames must satisfy 1 <= A_FRAME < B_FRAME <= FRAMES");
   end
   if ((1 << ADDR_W) <= 2 * NUM_REGS) begin : g_bad_aw
      $error("ADDR_W too narrow for the register map");
   end

   logic [BIT_W-1:0]    rx_bit_pos, tx_bit_pos;
   logic [FRM_W-1:0]    rx_frame_idx, tx_frame_idx;
   logic                rx_locked, tx_locked;
   logic                rx_sf_start, rx_sf_end, tx_sf_start, tx_sf_end;
   logic                rx_rob_a, rx_rob_b, tx_rob_a, tx_rob_b;
   logic [CH_W-1:0]     rx_rob_ch, tx_rob_ch;
   logic [CHANNELS-1:0] rx_sig_a, rx_sig_b;
   logic [CHANNELS-1:0] tx_stage_a, tx_stage_b, tx_act_a, tx_act_b;
   logic                force_ones;

   rbs_pos_ctr #(
      .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH), .FRAMES(FRAMES),
      .A_FRAME(A_FRAME), .B_FRAME(B_FRAME)
   ) rx_ctr_i (
      .clk(clk), .rst_n(rst_n), .sync(rx_sync),
      .bit_pos(rx_bit_pos), .frame_idx(rx_frame_idx), .locked(rx_locked),
      .sf_start(rx_sf_start), .sf_end(rx_sf_end),
      .rob_a(rx_rob_a), .rob_b(rx_rob_b), .rob_ch(rx_rob_ch)
   );

   rbs_pos_ctr #(
      .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH), .FRAMES(FRAMES),
      .A_FRAME(A_FRAME), .B_FRAME(B_FRAME)
   ) tx_ctr_i (
      .clk(clk), .rst_n(rst_n), .sync(tx_sync),
      .bit_pos(tx_bit_pos), .frame_idx(tx_frame_idx), .locked(tx_locked),
      .sf_start(tx_sf_start), .sf_end(tx_sf_end),
      .rob_a(tx_rob_a), .rob_b(tx_rob_b), .rob_ch(tx_rob_ch)
   );

   rbs_rx_cap #(.CHANNELS(CHANNELS)) rx_cap_i (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data),
      .rob_a(rx_rob_a), .rob_b(rx_rob_b), .rob_ch(rx_rob_ch),
      .sf_end(rx_sf_end), .force_ones(force_ones),
      .rx_ser_out(rx_ser_out), .sig_a(rx_sig_a), .sig_b(rx_sig_b)
   );

   rbs_tx_ins #(.CHANNELS(CHANNELS)) tx_ins_i (
      .clk(clk), .rst_n(rst_n), .tx_data_in(tx_data_in),
      .rob_a(tx_rob_a), .rob_b(tx_rob_b), .rob_ch(tx_rob_ch),
      .sf_start(tx_sf_start), .stage_a(tx_stage_a), .stage_b(tx_stage_b),
      .act_a(tx_act_a), .act_b(tx_act_b), .tx_ser_out(tx_ser_out)
   );

   rbs_regs #(.CHANNELS(CHANNELS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sig_a(rx_sig_a), .sig_b(rx_sig_b),
      .stage_a(tx_stage_a), .stage_b(tx_stage_b), .force_ones(force_ones)
   );
endmodule

// File: rtl/rbs_codec_chk.sv
module rbs_codec_chk #(
   parameter int unsigned CHANNELS = 24,
   parameter int unsigned FRAME_LEN = 193,
   parameter int unsigned FRAMES   = 12,
   parameter int unsigned BIT_W    = 8,
   parameter int unsigned FRM_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rx_data,
   input logic                rx_ser_out,
   input logic                tx_data_in,
   input logic                tx_ser_out,
   input logic                force_ones,
   input logic                rx_rob_a,
   input logic                rx_rob_b,
   input logic                tx_rob_a,
   input logic                tx_rob_b,
   input logic                rx_sf_end,
   input logic                tx_sf_start,
   input logic [BIT_W-1:0]    rx_bit_pos,
   input logic [FRM_W-1:0]    rx_frame_idx,
   input logic [BIT_W-1:0]    tx_bit_pos,
   input logic [FRM_W-1:0]    tx_frame_idx,
   input logic [CHANNELS-1:0] rx_sig_a,
   input logic [CHANNELS-1:0] rx_sig_b,
   input logic [CHANNELS-1:0] tx_act_a,
   input logic [CHANNELS-1:0] tx_act_b
);
   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R2
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rx_bit_pos) < FRAME_LEN) && (32'(rx_frame_idx) < FRAMES) &&
      (32'(tx_bit_pos) < FRAME_LEN) && (32'(tx_frame_idx) < FRAMES));

   // R2
   rob_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_rob_a, rx_rob_b}) && $onehot0({tx_rob_a, tx_rob_b}));

   // R3
   rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !($past(force_ones) && ($past(rx_rob_a) || $past(rx_rob_b)))
         |-> rx_ser_out == $past(rx_data));

   // R4
   rx_force_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      ($past(force_ones) && ($past(rx_rob_a) || $past(rx_rob_b))) |-> rx_ser_out);

   // R6
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !$past(rx_sf_end) |-> ($stable(rx_sig_a) && $stable(rx_sig_b)));

   // R8
   tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !($past(tx_rob_a) || $past(tx_rob_b)) |-> tx_ser_out == $past(tx_data_in));

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !$past(tx_sf_start) |-> ($stable(tx_act_a) && $stable(tx_act_b)));
endmodule

bind rbs_codec rbs_codec_chk #(
   .CHANNELS(CHANNELS), .FRAME_LEN(FRAME_LEN), .FRAMES(FRAMES),
   .BIT_W(BIT_W), .FRM_W(FRM_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ser_out(rx_ser_out),
   .tx_data_in(tx_data_in), .tx_ser_out(tx_ser_out), .force_ones(force_ones),
   .rx_rob_a(rx_rob_a), .rx_rob_b(rx_rob_b), .tx_rob_a(tx_rob_a), .tx_rob_b(tx_rob_b),
   .rx_sf_end(rx_sf_end), .tx_sf_start(tx_sf_start),
   .rx_bit_pos(rx_bit_pos), .rx_frame_idx(rx_frame_idx),
   .tx_bit_pos(tx_bit_pos), .tx_frame_idx(tx_frame_idx),
   .rx_sig_a(rx_sig_a), .rx_sig_b(rx_sig_b),
   .tx_act_a(tx_act_a), .tx_act_b(tx_act_b)
);

// File: tb/rbs_codec_tb.sv
module rbs_codec_tb_top;
   localparam int NCH  = 24;
   localparam int FLEN = 193;
   localparam int NFR  = 12;
   localparam int SFL  = NFR * FLEN;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_sync = 1'b0, rx_data = 1'b0, tx_sync = 1'b0, tx_data_in = 1'b0;
   logic       reg_wr = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       rx_ser_out, tx_ser_out;
   logic [7:0] reg_rdata;

   int total = 0;
   int bad = 0;

   bit       pat_a [NCH], pat_b [NCH];
   bit       prev_a[NCH], prev_b[NCH];
   bit       act_a [NCH], act_b [NCH];
   bit [7:0] tx_stage[12], tx_next[12];
   bit       force_m = 1'b0;

   always #2 clk = ~clk;

   rbs_codec dut_i (
      .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .rx_data(rx_data),
      .rx_ser_out(rx_ser_out), .tx_sync(tx_sync), .tx_data_in(tx_data_in),
      .tx_ser_out(tx_ser_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] rx_byte(input int k);
      return {prev_a[2*k], prev_b[2*k], prev_a[2*k], prev_b[2*k],
              prev_a[2*k+1], prev_b[2*k+1], prev_a[2*k+1], prev_b[2*k+1]};
   endfunction

   function automatic bit is_robbed(input int f, input int b);
      return (b != 0) && (b % 8 == 0) && (f == 5 || f == 11);
   endfunction

   task automatic wr_reg(input int a, input bit [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a >= 12 && a < 24) tx_stage[a-12] = d;
      if (a == 24) force_m = d[0];
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      @(negedge clk);
      reg_addr = 5'(a);
      #1;
      check(req, $sformatf("rdata@%0d", a), int'(reg_rdata), exp);
   endtask

   // One superframe on both sides; optional mid-superframe tx writes and rx reads.
   task automatic run_sf(input bit do_wr, input bit do_rd);
      bit exp_rx, exp_tx, rd_pend;
      int rd_exp;
      for (int c = 0; c < NCH; c++) begin
         act_a[c] = tx_stage[c/2][7 - 4*(c%2)];
         act_b[c] = tx_stage[c/2][6 - 4*(c%2)];
      end
      rd_pend = 1'b0; rd_exp = 0; exp_rx = 1'b0; exp_tx = 1'b0;
      for (int n = 0; n <= SFL; n++) begin
         @(negedge clk);
         if (n > 0) begin
            check(force_m ? "R4" : "R3", "rx_ser_out", int'(rx_ser_out), int'(exp_rx));
            check("R8", "tx_ser_out", int'(tx_ser_out), int'(exp_tx));
            if (rd_pend) check("R6", "mid-superframe rx read", int'(reg_rdata), rd_exp);
         end
         reg_wr = 1'b0; rd_pend = 1'b0;
         if (n < SFL) begin
            automatic int  f  = n / FLEN;
            automatic int  b  = n % FLEN;
            automatic bit  rb = is_robbed(f, b);
            automatic int  ch = b / 8 - 1;
            automatic bit  rd = 1'($urandom);
            automatic bit  td = 1'($urandom);
            if (rb) rd = (f == 5) ? pat_a[ch] : pat_b[ch];
            rx_sync = (n == 0); tx_sync = (n == 0);
            rx_data = rd; tx_data_in = td;
            exp_rx = (rb && force_m) ? 1'b1 : rd;
            exp_tx = rb ? ((f == 5) ? act_a[ch] : act_b[ch]) : td;
            if (do_wr && f == 2 && b >= 1 && b <= 12) begin
               reg_wr = 1'b1; reg_addr = 5'(12 + b - 1); reg_wdata = tx_next[b-1];
               tx_stage[b-1] = tx_next[b-1];
            end
            if (do_rd && f == 8 && b >= 1 && b <= 12) begin
               reg_addr = 5'(b - 1); rd_pend = 1'b1; rd_exp = int'(rx_byte(b - 1));
            end
         end else begin
            rx_sync = 1'b0; tx_sync = 1'b0; rx_data = 1'b0; tx_data_in = 1'b0;
         end
      end
      for (int c = 0; c < NCH; c++) begin
         prev_a[c] = pat_a[c]; prev_b[c] = pat_b[c];
      end
      for (int k = 0; k < 12; k++) rd_chk(k, int'(rx_byte(k)), "R5");
   endtask

   task automatic fill_pat(input int mode);
      for (int c = 0; c < NCH; c++) begin
         pat_a[c] = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom);
         pat_b[c] = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom);
      end
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      check("R1", "rx_ser_out in reset", int'(rx_ser_out), 0);
      check("R1", "tx_ser_out in reset", int'(tx_ser_out), 0);
      rst_n = 1'b1;
      for (int a = 0; a < 32; a++) rd_chk(a, 0, "R1");

      // R10: control bit, ignored rx writes, unmapped addresses
      wr_reg(24, 8'hFF);
      rd_chk(24, 1, "R10");
      wr_reg(3, 8'hFF);
      rd_chk(3, 0, "R10");
      for (int a = 25; a < 32; a++) rd_chk(a, 0, "R10");

      // R2: no sync seen yet, so force must not alter anything
      for (int n = 0; n < 2500; n++) begin
         automatic bit d = 1'($urandom);
         automatic bit t = 1'($urandom);
         @(negedge clk);
         rx_data = d; tx_data_in = t;
         @(negedge clk);
         check("R2", "pre-sync rx pass", int'(rx_ser_out), int'(d));
         check("R2", "pre-sync tx pass", int'(tx_ser_out), int'(t));
      end
      for (int k = 0; k < 12; k++) rd_chk(k, 0, "R2");

      // R7: transmit register readback
      for (int k = 0; k < 12; k++) wr_reg(12 + k, 8'($urandom));
      for (int k = 0; k < 12; k++) rd_chk(12 + k, int'(tx_stage[k]), "R7");

      fill_pat(1); run_sf(1'b0, 1'b1);              // all ones, forced
      wr_reg(24, 8'h00); rd_chk(24, 0, "R10");
      for (int k = 0; k < 12; k++) tx_next[k] = 8'($urandom);
      fill_pat(2); run_sf(1'b1, 1'b1);              // R9 mid-superframe writes
      for (int k = 0; k < 12; k++) rd_chk(12 + k, int'(tx_next[k]), "R7");
      fill_pat(2); run_sf(1'b0, 1'b1);              // new tx set now active
      wr_reg(24, 8'h01);
      fill_pat(0); run_sf(1'b0, 1'b1);              // all zeros, forced
      for (int k = 0; k < 12; k++) tx_next[k] = 8'($urandom);
      fill_pat(2); run_sf(1'b1, 1'b1);
      wr_reg(24, 8'h00);
      fill_pat(2); run_sf(1'b0, 1'b1);
      wr_reg(5, 8'h00);                             // R10 rx write ignored
      rd_chk(5, int'(rx_byte(5)), "R10");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule